// File: doc/BRIEF.md
# Auto-Incrementing Work-RAM Access Port

This block is a byte-wide register port that reaches a 128 KiB work RAM through a 17-bit address pointer, without mapping the RAM into the host's address space. Software sets the pointer with up to three byte writes: a low byte, a middle byte and a single top bit. It then moves a stream of bytes through one data register. Every data access, whether a read or a write, advances the pointer by one. The pointer wraps from the last RAM byte back to the first.

The host side takes one request per cycle: a valid strobe, a direction, a 2-bit register offset and a write byte. A read returns its byte with a response strobe one cycle after the request. The RAM side is a plain synchronous single-port interface with one cycle of read latency. Its address is the pointer register itself, so a read stream runs back to back at one byte per cycle. Reads of the three pointer offsets are not decoded. They return an open-bus byte that the surrounding fabric supplies with the request.

Top module: `wram_port`

## Requirements
- R1: A synchronous reset clears the pointer to 0x00000, so `ram_addr` reads 0 and `rsp_valid` and `ram_en` are low after reset.
- R2: A write to offset 1 replaces pointer bits 7:0 with the write byte and leaves bits 16:8 unchanged.
- R3: A write to offset 2 replaces pointer bits 15:8 with the write byte and leaves bits 16 and 7:0 unchanged.
- R4: A write to offset 3 sets pointer bit 16 from write-byte bit 0, ignores write-byte bits 7:1, and leaves bits 15:0 unchanged.
- R5: A write to offset 0 drives `ram_en`=1, `ram_we`=1, `ram_addr`=pointer and `ram_wdata`=write byte in the request cycle, and the pointer increments by one.
- R6: A read of offset 0 drives `ram_en`=1 and `ram_we`=0 at the pointer in the request cycle. The pointer increments by one. In the next cycle `rsp_valid` is 1 and `rsp_data` carries the RAM byte.
- R7: An increment from pointer 0x1FFFF yields 0x00000.
- R8: A read of offset 1, 2 or 3 makes no RAM access and leaves the pointer unchanged. In the next cycle `rsp_valid` is 1 and `rsp_data` equals the `open_bus` value presented with the request.
- R9: `rsp_valid` is 1 only in the cycle after a read request. Writes and idle cycles produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 2 | Register offset: 0 data, 1 pointer low, 2 pointer middle, 3 pointer top bit |
| req_wdata | input | 8 | Write byte |
| open_bus | input | 8 | Byte returned for reads of offsets 1 to 3 |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 8 | Read response byte |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 17 | RAM byte address (current pointer) |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, valid one cycle after a read access |

## Verification
The assertions take for granted that the RAM answers every read access with its byte exactly one cycle later. They also rely on the request inputs holding a defined value at each clock edge, with at most one request per cycle. The bench provides both. Its RAM model registers a sparse store on the same edge. Its tasks drive one request per cycle on the falling edge and return all request inputs to idle afterwards.

// File: rtl/wram_port_pkg.sv
package wram_port_pkg;

  typedef enum logic [1:0] {
    OFF_DATA = 2'd0,
    OFF_LO   = 2'd1,
    OFF_MID  = 2'd2,
    OFF_HI   = 2'd3
  } port_off_e;

  typedef struct packed {
    logic acc;      // data register access (read or write)
    logic we;       // data register write
    logic ld_lo;    // pointer low byte load
    logic ld_mid;   // pointer middle byte load
    logic ld_hi;    // pointer top bits load
    logic rd_open;  // read of an undecoded offset
  } port_cmd_t;

endpackage

// File: rtl/wram_port_decode.sv
module wram_port_decode
  import wram_port_pkg::*;
(
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [1:0] req_offset,
  output port_cmd_t  cmd
);

  port_off_e off;

  always_comb begin
    off         = port_off_e'(req_offset);
    cmd         = '0;
    cmd.acc     = req_valid && (off == OFF_DATA);
    cmd.we      = req_valid && req_write && (off == OFF_DATA);
    cmd.ld_lo   = req_valid && req_write && (off == OFF_LO);
    cmd.ld_mid  = req_valid && req_write && (off == OFF_MID);
    cmd.ld_hi   = req_valid && req_write && (off == OFF_HI);
    cmd.rd_open = req_valid && !req_write && (off != OFF_DATA);
  end

endmodule

// File: rtl/wram_port_ptr.sv
module wram_port_ptr #(
  parameter int PTR_W  = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              ld_lo,
  input  logic              ld_mid,
  input  logic              ld_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr
);

  localparam int MID_LSB = DATA_W;
  localparam int HI_LSB  = 2 * DATA_W;
  localparam int HI_W    = PTR_W - HI_LSB;

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (step) begin
      ptr_q <= ptr_q + PTR_W'(1);
    end else if (ld_lo) begin
      ptr_q[MID_LSB-1:0] <= wdata;
    end else if (ld_mid) begin
      ptr_q[HI_LSB-1:MID_LSB] <= wdata;
    end else if (ld_hi) begin
      ptr_q[PTR_W-1:HI_LSB] <= wdata[HI_W-1:0];
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/wram_port_resp.sv
module wram_port_resp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_ram,
  input  logic              rd_open,
  input  logic [DATA_W-1:0] open_bus,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic              vld_q;
  logic              sel_open_q;
  logic [DATA_W-1:0] open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q      <= 1'b0;
      sel_open_q <= 1'b0;
      open_q     <= '0;
    end else begin
      vld_q      <= rd_ram || rd_open;
      sel_open_q <= rd_open;
      if (rd_open) open_q <= open_bus;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = sel_open_q ? open_q : ram_rdata;

endmodule

// File: rtl/wram_port.sv
module wram_port
  import wram_port_pkg::*;
#(
  parameter int PTR_W  = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] open_bus,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              ram_en,
  output logic              ram_we,
  output logic [PTR_W-1:0]  ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);

  port_cmd_t        cmd;
  logic [PTR_W-1:0] ptr;

  wram_port_decode u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_offset(req_offset),
    .cmd       (cmd)
  );

  wram_port_ptr #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .step  (cmd.acc),
    .ld_lo (cmd.ld_lo),
    .ld_mid(cmd.ld_mid),
    .ld_hi (cmd.ld_hi),
    .wdata (req_wdata),
    .ptr   (ptr)
  );

  wram_port_resp #(.DATA_W(DATA_W)) u_resp (
    .clk      (clk),
    .rst      (rst),
    .rd_ram   (cmd.acc && !cmd.we),
    .rd_open  (cmd.rd_open),
    .open_bus (open_bus),
    .ram_rdata(ram_rdata),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  assign ram_en    = cmd.acc;
  assign ram_we    = cmd.we;
  assign ram_addr  = ptr;
  assign ram_wdata = req_wdata;

endmodule

// File: rtl/wram_port_checker.sv
module wram_port_checker #(
  parameter int PTR_W  = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_offset,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W-1:0] open_bus,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              ram_en,
  input logic              ram_we,
  input logic [PTR_W-1:0]  ram_addr,
  input logic [DATA_W-1:0] ram_wdata,
  input logic [DATA_W-1:0] ram_rdata
);

  logic data_acc, data_wr, open_rd;
  assign data_acc = req_valid && (req_offset == 2'd0);
  assign data_wr  = data_acc && req_write;
  assign open_rd  = req_valid && !req_write && (req_offset != 2'd0);

  assert_reset_ptr_R1: assert property (@(posedge clk)
    rst |=> (ram_addr == '0 && !rsp_valid));

  assert_lo_load_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_offset == 2'd1) |=>
      (ram_addr[DATA_W-1:0] == $past(req_wdata) &&
       ram_addr[PTR_W-1:DATA_W] == $past(ram_addr[PTR_W-1:DATA_W])));

  assert_hi_load_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_offset == 2'd3) |=>
      (ram_addr[PTR_W-1:2*DATA_W] == $past(req_wdata[PTR_W-2*DATA_W-1:0]) &&
       ram_addr[2*DATA_W-1:0] == $past(ram_addr[2*DATA_W-1:0])));

  assert_write_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    data_wr |-> (ram_en && ram_we && ram_wdata == req_wdata));

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
    data_acc |=> (ram_addr == PTR_W'($past(ram_addr) + 1'b1)));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (data_acc && ram_addr == '1) |=> (ram_addr == '0));

  assert_open_no_ram_R8: assert property (@(posedge clk) disable iff (rst)
    open_rd |-> !ram_en);

  assert_open_data_R8: assert property (@(posedge clk) disable iff (rst)
    open_rd |=> (rsp_valid && rsp_data == $past(open_bus)));

  assert_rsp_only_reads_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(ram_addr));

endmodule

bind wram_port wram_port_checker #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/wram_port_tb.sv
module wram_port_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_offset = 2'd0;
  logic [7:0]  req_wdata = 8'h00;
  logic [7:0]  open_bus = 8'h00;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        ram_en, ram_we;
  logic [16:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = 8'h00;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [16:0] exp_ptr;

  logic [7:0] mem [int];

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[int'(ram_addr)] = ram_wdata;
      else ram_rdata <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h00;
    end
  end

  wram_port u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_wdata(req_wdata), .open_bus(open_bus),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ram_en(ram_en),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request; returns response observed in the following cycle
  task automatic access(input bit wr, input logic [1:0] off, input logic [7:0] wd,
                        input logic [7:0] ob, output bit rv, output logic [7:0] rd,
                        output bit en, output bit we, output logic [16:0] addr);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = off; req_wdata = wd; open_bus = ob;
    #1;
    en = ram_en; we = ram_we; addr = ram_addr;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_offset = 2'd0; req_wdata = 8'h00; open_bus = 8'h00;
    #1;
    rv = rsp_valid; rd = rsp_data;
  endtask

  task automatic set_ptr(input logic [16:0] p);
    bit rv, en, we; logic [7:0] rd; logic [16:0] a;
    access(1'b1, 2'd1, p[7:0], 8'h00, rv, rd, en, we, a);
    access(1'b1, 2'd2, p[15:8], 8'h00, rv, rd, en, we, a);
    access(1'b1, 2'd3, {7'h55, p[16]}, 8'h00, rv, rd, en, we, a);
    exp_ptr = p;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check("R1 ram_addr after reset", int'(ram_addr), 0);
    check("R1 rsp_valid after reset", int'(rsp_valid), 0);
    check("R1 ram_en after reset", int'(ram_en), 0);
  endtask

  task automatic t_ptr_load();
    bit rv, en, we; logic [7:0] rd; logic [16:0] a;
    access(1'b1, 2'd1, 8'h34, 8'h00, rv, rd, en, we, a);
    check("R2 low byte load", int'(ram_addr), 'h00034);
    check("R2 no ram access", int'(en), 0);
    access(1'b1, 2'd2, 8'h12, 8'h00, rv, rd, en, we, a);
    check("R3 mid byte load", int'(ram_addr), 'h01234);
    access(1'b1, 2'd3, 8'hFF, 8'h00, rv, rd, en, we, a);
    check("R4 top bit set", int'(ram_addr), 'h11234);
    access(1'b1, 2'd1, 8'hA5, 8'h00, rv, rd, en, we, a);
    check("R2 upper bits kept", int'(ram_addr), 'h112A5);
    access(1'b1, 2'd2, 8'h7E, 8'h00, rv, rd, en, we, a);
    check("R3 other bits kept", int'(ram_addr), 'h17EA5);
    access(1'b1, 2'd3, 8'hFE, 8'h00, rv, rd, en, we, a);
    check("R4 bits 7:1 ignored", int'(ram_addr), 'h07EA5);
    check("R9 no rsp after write", int'(rv), 0);
  endtask

  task automatic t_stream_write();
    bit rv, en, we; logic [7:0] rd; logic [16:0] a;
    set_ptr(17'h01230);
    for (int i = 0; i < 4; i++) begin
      access(1'b1, 2'd0, 8'hC0 + 8'(i), 8'h00, rv, rd, en, we, a);
      check("R5 write enable", int'({en, we}), 3);
      check("R5 write address", int'(a), int'(exp_ptr));
      exp_ptr = exp_ptr + 17'd1;
      check("R5 pointer step", int'(ram_addr), int'(exp_ptr));
      check("R9 no rsp after data write", int'(rv), 0);
    end
    check("R5 stored byte", int'(mem[int'(17'h01232)]), 'hC2);
  endtask

  task automatic t_stream_read();
    bit rv, en, we; logic [7:0] rd; logic [16:0] a;
    set_ptr(17'h01230);
    for (int i = 0; i < 4; i++) begin
      access(1'b0, 2'd0, 8'h00, 8'h99, rv, rd, en, we, a);
      check("R6 read enable", int'({en, we}), 2);
      check("R6 read address", int'(a), int'(exp_ptr));
      check("R6 rsp_valid", int'(rv), 1);
      check("R6 rsp_data", int'(rd), 'hC0 + i);
      exp_ptr = exp_ptr + 17'd1;
      check("R6 pointer step", int'(ram_addr), int'(exp_ptr));
    end
  endtask

  task automatic t_wrap();
    bit rv, en, we; logic [7:0] rd; logic [16:0] a;
    set_ptr(17'h1FFFE);
    access(1'b1, 2'd0, 8'h11, 8'h00, rv, rd, en, we, a);
    access(1'b1, 2'd0, 8'h22, 8'h00, rv, rd, en, we, a);
    check("R7 wrap to zero", int'(ram_addr), 0);
    access(1'b1, 2'd0, 8'h33, 8'h00, rv, rd, en, we, a);
    check("R7 write after wrap at 0", int'(a), 0);
    set_ptr(17'h1FFFF);
    access(1'b0, 2'd0, 8'h00, 8'h00, rv, rd, en, we, a);
    check("R7 read at top", int'(rd), 'h22);
    check("R7 read wraps pointer", int'(ram_addr), 0);
    access(1'b0, 2'd0, 8'h00, 8'h00, rv, rd, en, we, a);
    check("R7 read after wrap", int'(rd), 'h33);
  endtask

  task automatic t_open_bus();
    bit rv, en, we; logic [7:0] rd; logic [16:0] a;
    set_ptr(17'h0ABCD);
    for (int o = 1; o < 4; o++) begin
      access(1'b0, 2'(o), 8'h00, 8'h40 + 8'(o), rv, rd, en, we, a);
      check("R8 no ram access", int'(en), 0);
      check("R8 rsp_valid", int'(rv), 1);
      check("R8 open bus data", int'(rd), 'h40 + o);
      check("R8 pointer unchanged", int'(ram_addr), 'h0ABCD);
    end
    @(negedge clk); #1;
    check("R9 idle no rsp", int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ptr_load();
    t_stream_write();
    t_stream_read();
    t_wrap();
    t_open_bus();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule